// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer arithmetic and logic unit of a small load/store processor core. Each cycle it takes two operand words, a shift count and a four-bit operation code. It produces a result word, a flag that marks an all-zero result, and a signed-overflow flag. The pipeline uses that flag to raise an arithmetic exception. Add and subtract each come in two flavours. The trapping flavour reports signed overflow. The wrapping flavour computes modulo 2^WIDTH and never reports it. Comparisons also come in two flavours, one that reads the operands as two's complement and one that reads them as unsigned.

The datapath is purely combinational. A single output register stage holds the result, zero flag and overflow flag, so the unit can be dropped into a pipeline stage and tested against a clock. The operation codes are fixed, because the instruction decoder upstream produces them. All other widths follow from the WIDTH parameter, whose default is 32.

Top module: `int_alu_reg`

## Requirements
- R1: Operation code 0 (trapping add) returns a_i + b_i modulo 2^WIDTH. The overflow flag is set exactly when the true two's-complement sum lies outside the signed range. For example, 0x7FFFFFFF + 1 gives 0x80000000 with overflow set, and 0xFFFFFFFF + 1 gives 0 with overflow clear.
- R2: Operation code 1 (trapping subtract) returns a_i - b_i modulo 2^WIDTH. The overflow flag is set exactly when the true signed difference does not fit. For example, 0x80000000 - 1 gives 0x7FFFFFFF with overflow set.
- R3: Operation codes 2 (wrapping add) and 3 (wrapping subtract) return the same result words as codes 0 and 1. Their overflow flag is always 0. For example, 0xFFFFFFFF + 1 gives 0 and 0x7FFFFFFF + 1 gives 0x80000000, both without overflow.
- R4: Operation code 4 (signed less-than) writes the full word 1 when a_i < b_i as two's-complement numbers, and 0 otherwise. All-ones compared against zero gives 1.
- R5: Operation code 5 (unsigned less-than) writes the full word 1 when a_i < b_i as unsigned numbers, and 0 otherwise. All-ones compared against zero gives 0.
- R6: Operation codes 4 to 9 (compares, bitwise operations and shifts) never set the overflow flag, whatever the operands. This holds even when the internal subtraction of a compare overflows.
- R7: Operation code 6 returns the bitwise AND of a_i and b_i. Operation code 7 returns their bitwise OR.
- R8: Operation code 8 shifts a_i left by shamt_i and operation code 9 shifts it right logically by shamt_i. Vacated bits fill with 0, and b_i is not used. A count of 0 returns a_i unchanged.
- R9: zero_o is 1 exactly when result_o is all zeros.
- R10: Outputs change only at the rising clock edge. They show the result of the inputs sampled at the most recent edge, and input changes between edges do not reach the outputs.
- R11: While rst_n is low (asynchronous, active low), result_o is 0, zero_o is 1 and ovf_o is 0.
- R12: Operation codes 10 to 15 are unused. They return a zero result word with overflow clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; output register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (0..9 defined, 10..15 unused) |
| a_i | input | WIDTH (32) | First operand; also the shifted operand |
| b_i | input | WIDTH (32) | Second operand |
| shamt_i | input | log2(WIDTH) (5) | Shift count |
| result_o | output | WIDTH (32) | Registered result word |
| zero_o | output | 1 | Registered all-zero flag of the result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The output register is the only storage in the block. A fault in the shared adder, in the compare derivation or in the shifter stages therefore appears on result_o or ovf_o at the first clock edge after the triggering operands. The run is arranged so that this happens within a single cycle. Edges where two operation codes diverge get their own operands: overflowing compares, sums that reach zero, and shift counts of 0 and WIDTH-1. These show a swapped carry sense, an inverted sign term or a missing shifter stage immediately as a wrong word or a stray overflow flag. A zero flag that drifts from its result word is visible in the same cycle on the two outputs together.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  // Operation codes are fixed by the upstream decoder.
  typedef enum logic [OP_W-1:0] {
    OP_ADD_T = 4'd0,
    OP_SUB_T = 4'd1,
    OP_ADD_W = 4'd2,
    OP_SUB_W = 4'd3,
    OP_SLT_S = 4'd4,
    OP_SLT_U = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_SLL   = 4'd8,
    OP_SRL   = 4'd9
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             sovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff        = sub ? ~b : b;
    {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    // Same-signed inputs with a differently signed output: signed overflow.
    sovf         = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data,
  input  logic [SHW-1:0]   amt,
  input  logic             right,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] fwd;
  logic [WIDTH-1:0] stage [0:SHW];

  // Right shifts reuse the left-shift network by mirroring the word.
  for (genvar i = 0; i < WIDTH; i++) begin : g_mirror_in
    assign fwd[i] = right ? data[WIDTH-1-i] : data[i];
  end

  assign stage[0] = fwd;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? (stage[s] << STEP) : stage[s];
  end

  for (genvar j = 0; j < WIDTH; j++) begin : g_mirror_out
    assign out[j] = right ? stage[SHW][WIDTH-1-j] : stage[SHW][j];
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             sovf;
  logic [WIDTH-1:0] shifted;
  logic             lt_s;
  logic             lt_u;

  // Compares share the subtractor with the arithmetic codes.
  assign do_sub = (op == OP_SUB_T) || (op == OP_SUB_W) ||
                  (op == OP_SLT_S) || (op == OP_SLT_U);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (a),
    .b     (b),
    .sub   (do_sub),
    .sum   (sum),
    .carry (carry),
    .sovf  (sovf)
  );

  alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .data  (a),
    .amt   (shamt),
    .right (op == OP_SRL),
    .out   (shifted)
  );

  always_comb begin
    // Signed: sign of the difference, corrected when it overflowed.
    lt_s = sum[MSB] ^ sovf;
    // Unsigned: a borrow means the carry out is clear.
    lt_u = ~carry;
  end

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_ADD_T, OP_SUB_T: begin
        result = sum;
        ovf    = sovf;
      end
      OP_ADD_W, OP_SUB_W: result = sum;
      OP_SLT_S:           result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLT_U:           result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_AND:             result = a & b;
      OP_OR:              result = a | b;
      OP_SLL, OP_SRL:     result = shifted;
      default: begin
        result = '0;
        ovf    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/int_alu_reg.sv
module int_alu_reg
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] res_d;
  logic             ovf_d;
  logic             zero_d;
  logic             upd_en;

  alu_core #(.WIDTH(WIDTH), .SHW(SHW)) u_core (
    .op     (op_i),
    .a      (a_i),
    .b      (b_i),
    .shamt  (shamt_i),
    .result (res_d),
    .ovf    (ovf_d)
  );

  // Next-state logic.
  always_comb begin
    zero_d = (res_d == '0);
    upd_en = 1'b1;
  end

  // Register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else if (upd_en) begin
      result_o <= res_d;
      zero_o   <= zero_d;
      ovf_o    <= ovf_d;
    end
  end

endmodule

// File: rtl/alu_chk.sv
module alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (result_o == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(op_i) == OP_ADD_W) || ($past(op_i) == OP_SUB_W)) |-> !ovf_o);

  // R6
  quiet_ops_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(op_i) >= OP_SLT_S) && ($past(op_i) <= OP_SRL)) |-> !ovf_o);

  // R4
  slt_word_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(op_i) == OP_SLT_S) || ($past(op_i) == OP_SLT_U))
      |-> (result_o[MSB:1] == '0));

  // R1
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(op_i) == OP_ADD_T) && ($past(a_i[MSB]) == $past(b_i[MSB])))
      |-> (ovf_o == (result_o[MSB] != $past(a_i[MSB]))));

  // R12
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(op_i) > OP_SRL) |-> ((result_o == '0) && !ovf_o));

  // R8
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((($past(op_i) == OP_SLL) || ($past(op_i) == OP_SRL)) && ($past(shamt_i) == '0))
      |-> (result_o == $past(a_i)));

endmodule

bind int_alu_reg alu_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/int_alu_reg_tb_top.sv
`timescale 1ns/1ps
module int_alu_reg_tb_top;

  localparam int  WIDTH = 32;
  localparam int  SHW   = 5;
  localparam time CLK_P = 20ns;

  logic             clk;
  logic             rst_n;
  logic [3:0]       op_i;
  logic [WIDTH-1:0] a_i;
  logic [WIDTH-1:0] b_i;
  logic [SHW-1:0]   shamt_i;
  logic [WIDTH-1:0] result_o;
  logic             zero_o;
  logic             ovf_o;

  int n_chk  = 0;
  int n_fail = 0;

  // Expected values of the inputs driven before the last edge.
  logic [WIDTH-1:0] exp_res;
  logic             exp_ovf;
  string            exp_tag;
  bit               have_exp = 0;

  int_alu_reg #(.WIDTH(WIDTH)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Behavioural model of one operation, in wide signed integers.
  task automatic model(input logic [3:0] op, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic [SHW-1:0] sh,
                       output logic [WIDTH-1:0] r, output logic v,
                       output string tag);
    longint sa, sb, sr;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    v  = 1'b0;
    case (op)
      4'd0: begin sr = sa + sb; r = sr[WIDTH-1:0];
              v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648); tag = "R1"; end
      4'd1: begin sr = sa - sb; r = sr[WIDTH-1:0];
              v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648); tag = "R2"; end
      4'd2: begin r = a + b; tag = "R3"; end
      4'd3: begin r = a - b; tag = "R3"; end
      4'd4: begin r = (sa < sb) ? 1 : 0; tag = "R4"; end
      4'd5: begin r = (a < b) ? 1 : 0; tag = "R5"; end
      4'd6: begin r = a & b; tag = "R7"; end
      4'd7: begin r = a | b; tag = "R7"; end
      4'd8: begin r = a << sh; tag = "R8"; end
      4'd9: begin r = a >> sh; tag = "R8"; end
      default: begin r = '0; tag = "R12"; end
    endcase
  endtask

  task automatic compare_prev();
    if (have_exp) begin
      check(exp_tag, result_o, exp_res);
      check((exp_tag == "R4" || exp_tag == "R5" || exp_tag == "R7" || exp_tag == "R8")
              ? "R6" : exp_tag, {31'd0, ovf_o}, {31'd0, exp_ovf});
      check("R9", {31'd0, zero_o}, {31'd0, (exp_res == '0)});
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic [SHW-1:0] sh);
    @(negedge clk);
    compare_prev();
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    model(op, a, b, sh, exp_res, exp_ovf, exp_tag);
    have_exp = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    compare_prev();
    have_exp = 0;
  endtask

  task automatic reset_check();
    check("R11", result_o, '0);
    check("R11", {31'd0, zero_o}, 32'd1);
    check("R11", {31'd0, ovf_o}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_i = 4'd0; a_i = 32'h1234_5678; b_i = 32'h0F0F_0F0F; shamt_i = 5'd3;
    #(CLK_P + 3ns);
    reset_check();
    @(negedge clk);
    rst_n = 1'b1;

    // R1 trapping add
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
    apply(4'd0, 32'h0000_0010, 32'h0000_0020, 5'd0);
    // R2 trapping subtract
    apply(4'd1, 32'h8000_0000, 32'd1, 5'd0);
    apply(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
    apply(4'd1, 32'd5, 32'd5, 5'd0);
    // R3 wrapping forms
    apply(4'd2, 32'hFFFF_FFFF, 32'd1, 5'd0);
    apply(4'd2, 32'h7FFF_FFFF, 32'd1, 5'd0);
    apply(4'd3, 32'h8000_0000, 32'd1, 5'd0);
    // R4 / R5 compares, including an overflowing internal subtract
    apply(4'd4, 32'hFFFF_FFFF, 32'd0, 5'd0);
    apply(4'd5, 32'hFFFF_FFFF, 32'd0, 5'd0);
    apply(4'd4, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    apply(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    apply(4'd5, 32'd9, 32'd9, 5'd0);
    // R7 bitwise
    apply(4'd6, 32'hF0F0_AAAA, 32'h0FF0_5555, 5'd0);
    apply(4'd7, 32'hF000_0001, 32'h000F_0002, 5'd0);
    // R8 shifts, b_i must be ignored
    apply(4'd8, 32'd0, 32'hDEAD_BEEF, 5'd0);
    apply(4'd8, 32'd1, 32'hFFFF_FFFF, 5'd31);
    apply(4'd9, 32'h8000_0000, 32'h1, 5'd31);
    apply(4'd9, 32'hCAFE_F00D, 32'h0, 5'd0);
    apply(4'd8, 32'hCAFE_F00D, 32'h0, 5'd4);
    apply(4'd9, 32'hCAFE_F00D, 32'h0, 5'd16);
    // R12 unused codes
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1);
    apply(4'd10, 32'h7FFF_FFFF, 32'd1, 5'd1);

    // R10: new inputs must not reach the outputs before the next edge
    apply(4'd2, 32'd5, 32'd6, 5'd0);
    apply(4'd2, 32'd1, 32'd1, 5'd0);
    #2ns;
    check("R10", result_o, 32'd11);

    // Mixed stream
    for (int k = 0; k < 400; k++) begin
      apply(4'($urandom_range(0, 15)), $urandom, $urandom, 5'($urandom_range(0, 31)));
    end
    flush();

    // R11: reset in the middle of a run
    @(negedge clk);
    op_i = 4'd0; a_i = 32'h7FFF_FFFF; b_i = 32'd1;
    @(negedge clk);
    rst_n = 1'b0;
    #2ns;
    reset_check();
    @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    apply(4'd1, 32'd3, 32'd10, 5'd0);
    flush();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule